// File: doc/BRIEF.md
# Pipelined search-tree pattern profiler

The block watches a bus and counts, exactly, how often each of a preloaded set of target values shows up on it. One pattern can arrive on every clock, with no stalls. The targets sit in a sorted binary search tree that is cut into pipeline levels. Level `s` owns `2^s` tree nodes. Each node has a stored pattern, a valid bit and a saturating counter. Each level also has a single comparator and a single incrementer.

A pattern enters at the root and moves down one level per clock, carrying the path it has taken so far as an index. At each level the stored node is compared with the pattern:

- **Equal:** the node's counter is bumped and the search ends.
- **Not equal:** one path bit is appended to the index and the pattern moves on to the next level.
- **Invalid slot:** the search ends silently.
- **Past the bottom level:** the search ends silently.

A host port loads the node patterns and reads back or clears the counters. Host writes are accepted only while profiling is switched off.

Top module: `pattern_profiler`

## Requirements
- R1: Each monitored cycle with `mon_valid`=1 and `prof_en`=1 whose pattern equals a valid node adds exactly one to that node's count. This holds for every value of a full sweep of the pattern space.
- R2: Search order. At a level, a pattern smaller than the node appends path bit 0 and a larger one appends path bit 1. The next index is therefore `2*index + bit`, and node (level s, index i) is reached by patterns whose ascending rank among a complete tree of `2^LEVELS-1` keys is `(2i+1)*2^(LEVELS-1-s) - 1`.
- R3: A match ends the search. When the same value is also stored in a deeper node on the equal-compare path (an equal compare appends bit 0), that deeper node's count is left unchanged.
- R4: A pattern that reaches an invalid slot, or that misses every level, changes no count.
- R5: Counts saturate. A count at all ones stays at all ones on a further match and never wraps to zero.
- R6: The same pattern arriving on consecutive cycles is counted once per cycle, with no lost update.
- R7: No count changes for a cycle with `mon_valid`=0, or for any cycle while `prof_en`=0.
- R8: Host address map. Bit `[HA_W-1]` selects the target: 0 for the pattern store, 1 for the count store. The next `SS_W` bits give the level. The low `IDX_W` bits give the index within the level. Read data appears on `h_rdata` on the cycle after `h_ren`, zero-extended. An index at or beyond the level's depth reads 0.
- R9: While `prof_en`=0, a host pattern write stores `h_wdata` into the slot and marks the slot valid, and a host count write clears the slot's count; the write data is ignored for a count write. While `prof_en`=1, both kinds of host write are ignored.
- R10: After reset every count reads 0, every pattern reads 0, every slot is invalid so no pattern matches, and `h_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prof_en | input | 1 | Profiling on (1), or host may write (0) |
| mon_valid | input | 1 | Monitored pattern present this cycle |
| mon_pat | input | PAT_W | Monitored bus pattern |
| h_ren | input | 1 | Host read strobe |
| h_wen | input | 1 | Host write strobe |
| h_addr | input | HA_W | Host address {target, level, index} |
| h_wdata | input | PAT_W | Host pattern write data |
| h_rdata | output | D_W | Registered host read data (D_W = max(PAT_W, CNT_W)) |

## Verification
The bench builds the block with `LEVELS`=4, `PAT_W`=8 and `CNT_W`=6. This gives 15 tree slots, an 8-bit pattern space that is swept completely, and 6-bit counters that saturate after a short burst of 63 matches.

The sweep sends every one of the 256 patterns a number of times derived arithmetically from its value, back to back, and mixes in idle cycles. The expected count for each node is then computed from the rank formula of R2. One leaf is left unloaded, and one duplicated value sits on an equal-compare path, so that the early-stop rule and the invalid-slot rule each have a visible effect.

// File: rtl/prof_pkg.sv
package prof_pkg;

  // host address target select, bit [HA_W-1]
  typedef enum logic {
    TGT_PATTERN = 1'b0,
    TGT_COUNT   = 1'b1
  } host_tgt_e;

  function automatic int unsigned wider(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/prof_stage.sv
module prof_stage #(
  parameter int unsigned S      = 0,
  parameter int unsigned LEVELS = 4,
  parameter int unsigned PAT_W  = 16,
  parameter int unsigned CNT_W  = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [PAT_W-1:0]              in_pat,
  input  logic [LEVELS-2:0]             in_idx,
  input  logic                          in_en,
  output logic [PAT_W-1:0]              out_pat,
  output logic [LEVELS-2:0]             out_idx,
  output logic                          out_en,
  input  logic [LEVELS-2:0]             h_idx,
  input  logic [PAT_W-1:0]              h_wdata,
  input  logic                          h_wr_pat,
  input  logic                          h_clr_cnt,
  output logic [PAT_W-1:0]              h_pat_rd,
  output logic [CNT_W-1:0]              h_cnt_rd,
  output logic                          o_hit,
  output logic                          o_cur_en
);

  localparam int unsigned IDX_W = LEVELS - 1;
  localparam int unsigned SW    = (S == 0) ? 1 : S;
  localparam int unsigned DEPTH = 1 << S;
  localparam int unsigned SLOTS = 1 << SW;

  function automatic logic dir_of(logic [PAT_W-1:0] p, logic [PAT_W-1:0] n);
    return p > n;
  endfunction

  function automatic logic [CNT_W-1:0] sat_inc(logic [CNT_W-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  function automatic logic [IDX_W-1:0] next_idx(logic [IDX_W-1:0] i, logic d);
    return (i << 1) | IDX_W'(d);
  endfunction

  // stage input pipeline registers
  logic [PAT_W-1:0] pat_q;
  logic [IDX_W-1:0] idx_q;
  logic             en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_q <= '0;
      idx_q <= '0;
      en_q  <= 1'b0;
    end else begin
      pat_q <= in_pat;
      idx_q <= in_idx;
      en_q  <= in_en;
    end
  end

  // level storage
  logic [SLOTS-1:0][PAT_W-1:0] pat_mem;
  logic [SLOTS-1:0]            vld_mem;
  logic [SLOTS-1:0][CNT_W-1:0] cnt_mem;

  logic [SW-1:0]    slot;
  logic [PAT_W-1:0] node_pat;
  logic             node_vld;
  logic             look;
  logic             hit;
  logic             go_on;
  logic             dir;

  assign slot     = idx_q[SW-1:0];
  assign node_pat = pat_mem[slot];
  assign node_vld = vld_mem[slot];
  assign look     = en_q & node_vld;
  assign hit      = look & (pat_q == node_pat);
  assign go_on    = look & ~hit;
  assign dir      = dir_of(pat_q, node_pat);

  assign out_pat  = pat_q;
  assign out_idx  = next_idx(idx_q, dir);
  assign out_en   = go_on;
  assign o_hit    = hit;
  assign o_cur_en = en_q;

  // host side of this level
  logic          h_in_range;
  logic [SW-1:0] h_s;
  logic          clr_now;
  logic          wr_now;

  assign h_in_range = (32'(h_idx) < DEPTH);
  assign h_s        = h_idx[SW-1:0];
  assign clr_now    = h_clr_cnt & h_in_range;
  assign wr_now     = h_wr_pat & h_in_range;
  assign h_pat_rd   = h_in_range ? pat_mem[h_s] : '0;
  assign h_cnt_rd   = h_in_range ? cnt_mem[h_s] : '0;

  // count read-modify-write in one cycle; host clear wins on the same slot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_mem <= '0;
    end else begin
      if (hit) cnt_mem[slot] <= sat_inc(cnt_mem[slot]);
      if (clr_now) cnt_mem[h_s] <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_mem <= '0;
      vld_mem <= '0;
    end else if (wr_now) begin
      pat_mem[h_s] <= h_wdata;
      vld_mem[h_s] <= 1'b1;
    end
  end

  // checker state: remember the last bump to see it land
  logic             chk_hit_q;
  logic             chk_clr_q;
  logic [SW-1:0]    chk_slot_q;
  logic [CNT_W-1:0] chk_old_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_hit_q  <= 1'b0;
      chk_clr_q  <= 1'b0;
      chk_slot_q <= '0;
      chk_old_q  <= '0;
    end else begin
      chk_hit_q  <= hit;
      chk_clr_q  <= clr_now && (h_s == slot);
      chk_slot_q <= slot;
      chk_old_q  <= cnt_mem[slot];
    end
  end

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_hit_q && !chk_clr_q && !(&chk_old_q) |-> cnt_mem[chk_slot_q] == chk_old_q + 1'b1);

  // R5
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_hit_q && !chk_clr_q && (&chk_old_q) |-> (&cnt_mem[chk_slot_q]));

  // R7
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q && !clr_now |=> $stable(cnt_mem));

endmodule

// File: rtl/prof_host_port.sv
module prof_host_port
  import prof_pkg::*;
#(
  parameter int unsigned LEVELS = 4,
  parameter int unsigned PAT_W  = 16,
  parameter int unsigned CNT_W  = 16,
  localparam int unsigned IDX_W = LEVELS - 1,
  localparam int unsigned SS_W  = $clog2(LEVELS),
  localparam int unsigned HA_W  = 1 + SS_W + IDX_W,
  localparam int unsigned D_W   = wider(PAT_W, CNT_W)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          prof_en,
  input  logic                          h_ren,
  input  logic                          h_wen,
  input  logic [HA_W-1:0]               h_addr,
  input  logic [LEVELS-1:0][PAT_W-1:0]  pat_rd_all,
  input  logic [LEVELS-1:0][CNT_W-1:0]  cnt_rd_all,
  output logic [IDX_W-1:0]              h_idx,
  output logic [LEVELS-1:0]             wr_pat_sel,
  output logic [LEVELS-1:0]             clr_sel,
  output logic [D_W-1:0]                h_rdata
);

  host_tgt_e       tgt;
  logic [SS_W-1:0] lvl;
  logic            wr_ok;
  logic            lvl_ok;

  assign tgt    = host_tgt_e'(h_addr[HA_W-1]);
  assign lvl    = h_addr[IDX_W +: SS_W];
  assign h_idx  = h_addr[IDX_W-1:0];
  assign wr_ok  = h_wen & ~prof_en;
  assign lvl_ok = (32'(lvl) < LEVELS);

  for (genvar g = 0; g < LEVELS; g++) begin : g_sel
    assign wr_pat_sel[g] = wr_ok && (tgt == TGT_PATTERN) && (32'(lvl) == g);
    assign clr_sel[g]    = wr_ok && (tgt == TGT_COUNT)   && (32'(lvl) == g);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_rdata <= '0;
    end else if (h_ren) begin
      if (!lvl_ok)                 h_rdata <= '0;
      else if (tgt == TGT_COUNT)   h_rdata <= D_W'(cnt_rd_all[lvl]);
      else                         h_rdata <= D_W'(pat_rd_all[lvl]);
    end
  end

  // R8
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !h_ren |=> $stable(h_rdata));

  // R9
  wr_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prof_en |-> (wr_pat_sel == '0) && (clr_sel == '0));

endmodule

// File: rtl/pattern_profiler.sv
module pattern_profiler
  import prof_pkg::*;
#(
  parameter int unsigned LEVELS = 4,
  parameter int unsigned PAT_W  = 16,
  parameter int unsigned CNT_W  = 16,
  localparam int unsigned IDX_W = LEVELS - 1,
  localparam int unsigned SS_W  = $clog2(LEVELS),
  localparam int unsigned HA_W  = 1 + SS_W + IDX_W,
  localparam int unsigned D_W   = wider(PAT_W, CNT_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prof_en,
  input  logic             mon_valid,
  input  logic [PAT_W-1:0] mon_pat,
  input  logic             h_ren,
  input  logic             h_wen,
  input  logic [HA_W-1:0]  h_addr,
  input  logic [PAT_W-1:0] h_wdata,
  output logic [D_W-1:0]   h_rdata
);

  logic [LEVELS-1:0][PAT_W-1:0] ch_pat;
  logic [LEVELS-1:0][IDX_W-1:0] ch_idx;
  logic [LEVELS-1:0]            ch_en;
  logic [LEVELS-1:0][PAT_W-1:0] nx_pat;
  logic [LEVELS-1:0][IDX_W-1:0] nx_idx;
  logic [LEVELS-1:0]            nx_en;
  logic [LEVELS-1:0]            hit_v;
  logic [LEVELS-1:0]            en_v;

  logic [LEVELS-1:0][PAT_W-1:0] pat_rd_all;
  logic [LEVELS-1:0][CNT_W-1:0] cnt_rd_all;
  logic [IDX_W-1:0]             h_idx;
  logic [LEVELS-1:0]            wr_pat_sel;
  logic [LEVELS-1:0]            clr_sel;

  logic [PAT_W-1:0] tail_pat;
  logic [IDX_W-1:0] tail_idx;
  logic             tail_en;

  assign ch_pat[0] = mon_pat;
  assign ch_idx[0] = '0;
  assign ch_en[0]  = prof_en & mon_valid;

  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    if (g > 0) begin : g_link
      assign ch_pat[g] = nx_pat[g-1];
      assign ch_idx[g] = nx_idx[g-1];
      assign ch_en[g]  = nx_en[g-1];
    end

    prof_stage #(
      .S(g), .LEVELS(LEVELS), .PAT_W(PAT_W), .CNT_W(CNT_W)
    ) u_st (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_pat   (ch_pat[g]),
      .in_idx   (ch_idx[g]),
      .in_en    (ch_en[g]),
      .out_pat  (nx_pat[g]),
      .out_idx  (nx_idx[g]),
      .out_en   (nx_en[g]),
      .h_idx    (h_idx),
      .h_wdata  (h_wdata),
      .h_wr_pat (wr_pat_sel[g]),
      .h_clr_cnt(clr_sel[g]),
      .h_pat_rd (pat_rd_all[g]),
      .h_cnt_rd (cnt_rd_all[g]),
      .o_hit    (hit_v[g]),
      .o_cur_en (en_v[g])
    );

    if (g < LEVELS - 1) begin : g_stop
      // R3
      stop_after_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_v[g] |=> !en_v[g+1]);
    end
  end

  assign tail_pat = nx_pat[LEVELS-1];
  assign tail_idx = nx_idx[LEVELS-1];
  assign tail_en  = nx_en[LEVELS-1];

  prof_host_port #(
    .LEVELS(LEVELS), .PAT_W(PAT_W), .CNT_W(CNT_W)
  ) u_host (
    .clk        (clk),
    .rst_n      (rst_n),
    .prof_en    (prof_en),
    .h_ren      (h_ren),
    .h_wen      (h_wen),
    .h_addr     (h_addr),
    .pat_rd_all (pat_rd_all),
    .cnt_rd_all (cnt_rd_all),
    .h_idx      (h_idx),
    .wr_pat_sel (wr_pat_sel),
    .clr_sel    (clr_sel),
    .h_rdata    (h_rdata)
  );

  // R7
  launch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(prof_en && mon_valid) |=> !en_v[0]);

  // R4
  tail_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tail_en |-> !hit_v[LEVELS-1] && tail_pat == $past(ch_pat[LEVELS-1]) &&
                (tail_idx >> 1) == ($past(ch_idx[LEVELS-1]) & IDX_W'((1 << (IDX_W-1)) - 1)));

endmodule

// File: tb/pattern_profiler_tb.sv
`timescale 1ns/1ps
module pattern_profiler_tb;

  localparam int LEVELS = 4;
  localparam int PAT_W  = 8;
  localparam int CNT_W  = 6;
  localparam int IDX_W  = LEVELS - 1;
  localparam int HA_W   = 1 + 2 + IDX_W;
  localparam int D_W    = 8;
  localparam int CMAX   = (1 << CNT_W) - 1;
  localparam int BAD_S  = 3;
  localparam int BAD_I  = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             prof_en = 1'b0;
  logic             mon_valid = 1'b0;
  logic [PAT_W-1:0] mon_pat = '0;
  logic             h_ren = 1'b0;
  logic             h_wen = 1'b0;
  logic [HA_W-1:0]  h_addr = '0;
  logic [PAT_W-1:0] h_wdata = '0;
  logic [D_W-1:0]   h_rdata;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pattern_profiler #(.LEVELS(LEVELS), .PAT_W(PAT_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .prof_en(prof_en), .mon_valid(mon_valid),
    .mon_pat(mon_pat), .h_ren(h_ren), .h_wen(h_wen), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_rdata(h_rdata)
  );

  function automatic int rank_of(int s, int i);
    return (2 * i + 1) * (1 << (LEVELS - 1 - s)) - 1;
  endfunction

  function automatic int key_of(int r);
    return 10 + 12 * r;
  endfunction

  function automatic int mult(int p);
    return (p % 3) + 1;
  endfunction

  function automatic logic [HA_W-1:0] haddr(int sel, int s, int i);
    return {sel[0], s[1:0], i[2:0]};
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic send(int p, bit v);
    @(negedge clk);
    mon_pat = p[PAT_W-1:0];
    mon_valid = v;
  endtask

  task automatic drain();
    @(negedge clk);
    mon_valid = 1'b0;
    repeat (LEVELS + 2) @(negedge clk);
  endtask

  task automatic hwrite(logic [HA_W-1:0] a, int d);
    @(negedge clk);
    h_addr = a; h_wdata = d[PAT_W-1:0]; h_wen = 1'b1;
    @(negedge clk);
    h_wen = 1'b0;
  endtask

  task automatic hread(logic [HA_W-1:0] a, output int v);
    @(negedge clk);
    h_addr = a; h_ren = 1'b1;
    @(negedge clk);
    h_ren = 1'b0;
    v = int'(h_rdata);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    check("R10 rdata after reset", int'(h_rdata), 0);
    hread(haddr(1, 0, 0), v); check("R10 root count", v, 0);
    hread(haddr(0, 2, 3), v); check("R10 pattern reads 0", v, 0);
    prof_en = 1'b1;
    repeat (3) send(0, 1'b1);
    drain();
    prof_en = 1'b0;
    hread(haddr(1, 0, 0), v); check("R10 empty slot no match", v, 0);

    // load the tree, one leaf left empty
    for (int s = 0; s < LEVELS; s++)
      for (int i = 0; i < (1 << s); i++)
        if (!(s == BAD_S && i == BAD_I)) hwrite(haddr(0, s, i), key_of(rank_of(s, i)));

    // R8: pattern readback, map and range
    for (int s = 0; s < LEVELS; s++)
      for (int i = 0; i < (1 << s); i++) begin
        hread(haddr(0, s, i), v);
        check("R8 pattern readback", v,
              (s == BAD_S && i == BAD_I) ? 0 : key_of(rank_of(s, i)));
      end
    hread(haddr(0, 0, 1), v); check("R8 index beyond depth", v, 0);

    // R1 R2 R6 R7: full sweep with repeats and idle cycles
    prof_en = 1'b1;
    for (int p = 0; p < (1 << PAT_W); p++) begin
      for (int k = 0; k < mult(p); k++) send(p, 1'b1);
      send(key_of(7), 1'b0);
    end
    drain();
    prof_en = 1'b0;
    for (int s = 0; s < LEVELS; s++)
      for (int i = 0; i < (1 << s); i++) begin
        hread(haddr(1, s, i), v);
        if (s == BAD_S && i == BAD_I) check("R4 invalid leaf count", v, 0);
        else check("R1 R2 R6 sweep count", v, mult(key_of(rank_of(s, i))));
      end

    // R7: profiling off ignores the bus
    repeat (5) send(key_of(7), 1'b1);
    drain();
    hread(haddr(1, 0, 0), v); check("R7 prof_en low", v, mult(key_of(7)));

    // R5: saturation
    prof_en = 1'b1;
    repeat (70) send(key_of(7), 1'b1);
    drain();
    prof_en = 1'b0;
    hread(haddr(1, 0, 0), v); check("R5 saturate", v, CMAX);
    hread(haddr(1, 1, 0), v); check("R5 neighbour untouched", v, mult(key_of(3)));

    // R9: host writes locked while profiling, accepted otherwise
    prof_en = 1'b1;
    hwrite(haddr(1, 0, 0), 0);
    hwrite(haddr(0, 1, 0), 8'h55);
    prof_en = 1'b0;
    hread(haddr(1, 0, 0), v); check("R9 clear ignored", v, CMAX);
    hread(haddr(0, 1, 0), v); check("R9 pattern write ignored", v, key_of(3));
    hwrite(haddr(1, 0, 0), 8'hff);
    hread(haddr(1, 0, 0), v); check("R9 clear", v, 0);

    // R3: duplicate on equal-compare path is never reached
    hwrite(haddr(0, 1, 0), key_of(7));
    hwrite(haddr(1, 1, 0), 0);
    prof_en = 1'b1;
    repeat (4) send(key_of(7), 1'b1);
    drain();
    prof_en = 1'b0;
    hread(haddr(1, 0, 0), v); check("R3 root counted", v, 4);
    hread(haddr(1, 1, 0), v); check("R3 deeper duplicate", v, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule